// File: doc/BRIEF.md
# Small-Page NAND Command and Address Front End

This block is the device-side front end of a small-page NAND flash model. It samples the chip-enable, command-latch, address-latch, write-protect and spare-suppress pins, together with an 8-bit data bus, on a one-cycle write strobe. From these it captures command bytes and builds a multi-byte address register. It also decides the exact strobe on which a read, an identification sequence or a program window begins.

A separate array engine holds the storage. This block sends it page-load, program and erase requests, moves program data bytes to it, and takes read data from it through a pop handshake. The read strobe returns array data, the identification bytes or the status byte, depending on the last command accepted. The ready/busy output always reports ready.

Top module: `nandsp_front`

## Requirements
- R1: A byte is taken as a command only on a write strobe with `ce_n` low and `cle` high. A byte strobed while `ce_n` is high does not change the command in force.
- R2: Each accepted command clears the address-cycle counter. Address byte k (k = 0, 1, 2, ...) goes into bits [8k+7:8k] of the address register, and the counter then advances by one.
- R3: In read mode, a page load starts on the write strobe that completes the third address cycle, and not before. `load_req` pulses for one cycle, `load_addr` carries the whole address register, and `load_col` carries address bits [7:0] plus any column offset.
- R4: Command 0x00 selects read with no column offset. Command 0x01 selects read with an offset of 256. Command 0x50 selects read with an offset equal to the page size, which points into the spare area.
- R5: Command 0x90 followed by one address cycle arms an identification stream. Four reads return, in order, the manufacturer ID, the device ID, a filler byte and 0xC0. Any later read returns 0.
- R6: After a load, each read forwards `arr_rdata` and pulses `arr_pop`. This continues for (page + page/32 − column) reads when `gnd` was low at the load, or for (page − column) reads when `gnd` was high. After that, reads return 0 and do not pop.
- R7: Command 0x80 followed by three address cycles opens a program window. Each later data byte (`cle` and `ale` low, `ce_n` low) is pushed out on `wr_push`/`wr_data`, up to page + page/32 bytes. Command 0x10 then pulses `prog_req` with the address register on `prog_addr`.
- R8: Command 0x60, then address cycles, then 0xD0 pulses `erase_req`. `erase_addr` carries the collected row bytes shifted left by 8 bits.
- R9: While `wp_n` is low, command 0x10 and command 0xD0 raise no request.
- R10: After command 0x70, every read returns the status byte and never pops the array. Status bit 7 equals `wp_n`, bit 6 is busy and bit 0 is error, and both of those read 0.
- R11: Command 0xFF returns the block to read mode. It clears the address register, the address-cycle counter and the column offset, and clears status bits 6..0.
- R12: A read strobe with `ce_n` high returns 0. A command code outside the set in R4, R5, R7, R8, R10 and R11 leaves the mode unchanged.
- R13: `rb_n` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_stb | input | 1 | One-cycle write strobe; pins and `io_in` are sampled on it |
| re_stb | input | 1 | One-cycle read strobe; `io_out` updates on it |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| gnd | input | 1 | High: reads stop at the end of the main page area |
| io_in | input | 8 | Data bus in |
| io_out | output | 8 | Data bus out, registered |
| rb_n | output | 1 | Ready/busy, always ready |
| load_req | output | 1 | Page load request pulse |
| load_addr | output | ADDR_BYTES*8 | Address register at load |
| load_col | output | clog2(PAGE+PAGE/32+1)+1 | Starting column including offset |
| arr_rdata | input | 8 | Current read byte from the array engine |
| arr_pop | output | 1 | Consume one read byte |
| wr_push | output | 1 | Program data byte valid |
| wr_data | output | 8 | Program data byte |
| prog_req | output | 1 | Program confirm pulse |
| prog_addr | output | ADDR_BYTES*8 | Address for program |
| erase_req | output | 1 | Erase confirm pulse |
| erase_addr | output | ADDR_BYTES*8 | Row bytes shifted to a byte address |

## Verification
The bench builds the block with a 512-byte page, four address bytes, an 8-bit bus and ID bytes 0xEC/0x75/0xA5. With these values the 16-byte spare area and the 256 offset both fall inside the column range. This lets one run reach the page-end and spare-end read limits, an offset that lands the column in the last byte or past the limit, and the program cap of 528 bytes. The column shift used in 16-bit mode is not exercised by this build.

// File: rtl/nandsp_pkg.sv
// Shared codes and mode type for the small-page NAND front end.
// Assumes an 8-bit command bus; command values are fixed by the device protocol.
package nandsp_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_ID     = 3'd1,
        OP_PROG   = 3'd2,
        OP_PROGC  = 3'd3,
        OP_ERASE  = 3'd4,
        OP_ERASEC = 3'd5,
        OP_STATUS = 3'd6
    } op_e;

    localparam logic [7:0] C_READ    = 8'h00;
    localparam logic [7:0] C_READ_HI = 8'h01;
    localparam logic [7:0] C_READ_SP = 8'h50;
    localparam logic [7:0] C_IDENT   = 8'h90;
    localparam logic [7:0] C_RESET   = 8'hFF;
    localparam logic [7:0] C_PSET    = 8'h80;
    localparam logic [7:0] C_PGO     = 8'h10;
    localparam logic [7:0] C_ESET    = 8'h60;
    localparam logic [7:0] C_EGO     = 8'hD0;
    localparam logic [7:0] C_STAT    = 8'h70;

    localparam logic [7:0] ID_TAIL   = 8'hC0;
    localparam int         ID_LEN    = 4;

endpackage

// File: rtl/nandsp_addr_asm.sv
// Address assembler: places each address byte into its byte lane and counts cycles.
// Assumes: a command byte restarts the count; bytes beyond ADDR_BYTES are dropped;
// with BUS16 set, the register shifts left by one on the second cycle (word to byte column).
module nandsp_addr_asm #(
    parameter int ADDR_BYTES = 4,
    parameter int BUS16      = 0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                soft_clr,
    input  logic                                cmd_take,
    input  logic                                byte_take,
    input  logic [7:0]                          din,
    output logic [ADDR_BYTES*8-1:0]             addr_nx,
    output logic                                cyc_hit,
    output logic [$clog2(ADDR_BYTES+2)-1:0]     cyc_idx
);
    localparam int AW      = ADDR_BYTES * 8;
    localparam int CNT_W   = $clog2(ADDR_BYTES + 2);
    localparam int CNT_MAX = ADDR_BYTES + 1;

    logic [AW-1:0]    addr_q;
    logic [CNT_W-1:0] cnt_q, base_cnt, cnt_nx;

    // Next address and cycle index for this strobe.
    always_comb begin
        base_cnt = cmd_take ? '0 : cnt_q;
        addr_nx  = addr_q;
        cyc_hit  = 1'b0;
        cyc_idx  = base_cnt;
        cnt_nx   = base_cnt;
        if (soft_clr) begin
            addr_nx = '0;
            cnt_nx  = '0;
        end else if (byte_take) begin
            cyc_hit = 1'b1;
            if (int'(base_cnt) < ADDR_BYTES)
                addr_nx[8*int'(base_cnt) +: 8] = din;
            if (int'(base_cnt) < CNT_MAX)
                cyc_idx = base_cnt + CNT_W'(1);
            cnt_nx = cyc_idx;
            if (cyc_idx == CNT_W'(2))
                addr_nx = addr_nx << BUS16;
        end
    end

    // Hold address and cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_nx;
            cnt_q  <= cnt_nx;
        end
    end

endmodule

// File: rtl/nandsp_cmd_dec.sv
// Command decoder: tracks the mode, the one-shot column offset and the program window,
// and issues load, program and erase requests.
// Assumes small-page timing: operations open on the third address cycle; PAGE_BYTES >= 256.
module nandsp_cmd_dec
    import nandsp_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int ADDR_BYTES = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          we_stb,
    input  logic                                          ce_n,
    input  logic                                          cle,
    input  logic                                          ale,
    input  logic                                          wp_n,
    input  logic                                          gnd,
    input  logic [7:0]                                    din,
    input  logic [ADDR_BYTES*8-1:0]                       addr_nx,
    input  logic                                          cyc_hit,
    input  logic [$clog2(ADDR_BYTES+2)-1:0]               cyc_idx,
    output logic                                          cmd_take,
    output logic                                          soft_clr,
    output op_e                                           op_q,
    output logic                                          id_start,
    output logic                                          len_load,
    output logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5)+1)-1:0] len_val,
    output logic                                          load_req,
    output logic [ADDR_BYTES*8-1:0]                       load_addr,
    output logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5)+1):0] load_col,
    output logic                                          prog_req,
    output logic [ADDR_BYTES*8-1:0]                       prog_addr,
    output logic                                          erase_req,
    output logic [ADDR_BYTES*8-1:0]                       erase_addr,
    output logic                                          wr_push,
    output logic [7:0]                                    wr_data
);
    localparam int SPARE = PAGE_BYTES >> 5;
    localparam int FULL  = PAGE_BYTES + SPARE;
    localparam int LEN_W = $clog2(FULL + 1);
    localparam int COL_W = LEN_W + 1;
    localparam int CNT_W = $clog2(ADDR_BYTES + 2);

    logic             known, start_hit, data_take;
    op_e              new_op, op_eff;
    logic [COL_W-1:0] off_q, col_sum, lim;
    logic             armed_q;
    logic [LEN_W-1:0] wcnt_q;

    // Recognise command codes and map them to a mode.
    always_comb begin
        known  = 1'b1;
        new_op = op_q;
        case (din)
            C_READ, C_READ_HI, C_READ_SP, C_RESET: new_op = OP_READ;
            C_IDENT: new_op = OP_ID;
            C_PSET:  new_op = OP_PROG;
            C_PGO:   new_op = OP_PROGC;
            C_ESET:  new_op = OP_ERASE;
            C_EGO:   new_op = OP_ERASEC;
            C_STAT:  new_op = OP_STATUS;
            default: known  = 1'b0;
        endcase
    end

    // Strobe qualification and start decisions.
    always_comb begin
        cmd_take  = we_stb && !ce_n && cle;
        soft_clr  = cmd_take && (din == C_RESET);
        op_eff    = (cmd_take && known) ? new_op : op_q;
        start_hit = cyc_hit && (cyc_idx == CNT_W'(3));
        id_start  = cyc_hit && (cyc_idx == CNT_W'(1)) && (op_eff == OP_ID);
        data_take = we_stb && !ce_n && !cle && !ale && (op_q == OP_PROG)
                    && armed_q && (int'(wcnt_q) < FULL);
        col_sum   = COL_W'(addr_nx[7:0]) + off_q;
        lim       = gnd ? COL_W'(PAGE_BYTES) : COL_W'(FULL);
        len_load  = start_hit && (op_eff == OP_READ);
        len_val   = (col_sum < lim) ? LEN_W'(lim - col_sum) : '0;
    end

    // Mode, offset, program window and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_READ;
            off_q      <= '0;
            armed_q    <= 1'b0;
            wcnt_q     <= '0;
            load_req   <= 1'b0;
            load_addr  <= '0;
            load_col   <= '0;
            prog_req   <= 1'b0;
            prog_addr  <= '0;
            erase_req  <= 1'b0;
            erase_addr <= '0;
            wr_push    <= 1'b0;
            wr_data    <= '0;
        end else begin
            load_req  <= 1'b0;
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            wr_push   <= 1'b0;
            if (cmd_take && known) begin
                op_q <= new_op;
                case (din)
                    C_READ:    off_q <= '0;
                    C_READ_HI: off_q <= COL_W'(256);
                    C_READ_SP: off_q <= COL_W'(PAGE_BYTES);
                    C_RESET: begin
                        off_q   <= '0;
                        armed_q <= 1'b0;
                        wcnt_q  <= '0;
                    end
                    C_PSET: begin
                        armed_q <= 1'b0;
                        wcnt_q  <= '0;
                    end
                    C_PGO: begin
                        armed_q <= 1'b0;
                        if (wp_n) begin
                            prog_req  <= 1'b1;
                            prog_addr <= addr_nx;
                        end
                    end
                    C_EGO: begin
                        if (wp_n) begin
                            erase_req  <= 1'b1;
                            erase_addr <= addr_nx << 8;
                        end
                    end
                    default: ;
                endcase
            end
            if (start_hit && (op_eff == OP_READ)) begin
                load_req  <= 1'b1;
                load_addr <= addr_nx;
                load_col  <= col_sum;
                off_q     <= '0;
            end
            if (start_hit && (op_eff == OP_PROG)) begin
                armed_q <= 1'b1;
                wcnt_q  <= '0;
            end
            if (data_take) begin
                wr_push <= 1'b1;
                wr_data <= din;
                wcnt_q  <= wcnt_q + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/nandsp_rd_path.sv
// Read data path: picks the byte for each read strobe from status, the ID stream or the array.
// Assumes the read counter is loaded by the decoder at page-load time; status bits 6..0 idle at 0.
module nandsp_rd_path
    import nandsp_pkg::*;
#(
    parameter logic [7:0] MANF_ID = 8'hEC,
    parameter logic [7:0] DEV_ID  = 8'h75,
    parameter logic [7:0] FILL_ID = 8'hA5,
    parameter int         LEN_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             re_stb,
    input  logic             ce_n,
    input  logic             wp_n,
    input  op_e              op,
    input  logic             cmd_take,
    input  logic             soft_clr,
    input  logic             id_start,
    input  logic             len_load,
    input  logic [LEN_W-1:0] len_val,
    input  logic [7:0]       arr_rdata,
    output logic [7:0]       io_out,
    output logic             arr_pop
);
    localparam int IDX_W = $clog2(ID_LEN + 1);

    logic [7:0]       stat_q;
    logic [LEN_W-1:0] rem_q;
    logic [IDX_W-1:0] idx_q;
    logic             id_live_q;
    logic [7:0]       id_byte;

    // Select the identification byte at the current index.
    always_comb begin
        case (idx_q)
            IDX_W'(0): id_byte = MANF_ID;
            IDX_W'(1): id_byte = DEV_ID;
            IDX_W'(2): id_byte = FILL_ID;
            default:   id_byte = ID_TAIL;
        endcase
    end

    // Array consume handshake for reads in read mode.
    always_comb arr_pop = re_stb && !ce_n && (op == OP_READ) && (rem_q != '0);

    // Status register: bit 7 mirrors the protect pin.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 8'h00;
        else        stat_q <= {wp_n, soft_clr ? 7'd0 : stat_q[6:0]};
    end

    // Read counter, ID pointer and output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            idx_q     <= '0;
            id_live_q <= 1'b0;
            io_out    <= 8'h00;
        end else begin
            if (re_stb) begin
                if (ce_n) begin
                    io_out <= 8'h00;
                end else begin
                    case (op)
                        OP_STATUS: io_out <= stat_q;
                        OP_ID: begin
                            if (id_live_q && (int'(idx_q) < ID_LEN)) begin
                                io_out <= id_byte;
                                idx_q  <= idx_q + IDX_W'(1);
                            end else begin
                                io_out <= 8'h00;
                            end
                        end
                        OP_READ: begin
                            if (rem_q != '0) begin
                                io_out <= arr_rdata;
                                rem_q  <= rem_q - LEN_W'(1);
                            end else begin
                                io_out <= 8'h00;
                            end
                        end
                        default: io_out <= 8'h00;
                    endcase
                end
            end
            if (cmd_take) id_live_q <= 1'b0;
            if (id_start) begin
                id_live_q <= 1'b1;
                idx_q     <= '0;
            end
            if (len_load) rem_q <= len_val;
            if (soft_clr) rem_q <= '0;
        end
    end

endmodule

// File: rtl/nandsp_front.sv
// Top of the small-page NAND front end: pin sampling, command decode, address
// assembly and read data selection. Assumes one-cycle strobes in the clk domain.
module nandsp_front
    import nandsp_pkg::*;
#(
    parameter logic [7:0] MANF_ID    = 8'hEC,
    parameter logic [7:0] DEV_ID     = 8'h75,
    parameter logic [7:0] FILL_ID    = 8'hA5,
    parameter int         PAGE_BYTES = 512,
    parameter int         ADDR_BYTES = 4,
    parameter int         BUS16      = 0
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          we_stb,
    input  logic                                          re_stb,
    input  logic                                          ce_n,
    input  logic                                          cle,
    input  logic                                          ale,
    input  logic                                          wp_n,
    input  logic                                          gnd,
    input  logic [7:0]                                    io_in,
    output logic [7:0]                                    io_out,
    output logic                                          rb_n,
    output logic                                          load_req,
    output logic [ADDR_BYTES*8-1:0]                       load_addr,
    output logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5)+1):0] load_col,
    input  logic [7:0]                                    arr_rdata,
    output logic                                          arr_pop,
    output logic                                          wr_push,
    output logic [7:0]                                    wr_data,
    output logic                                          prog_req,
    output logic [ADDR_BYTES*8-1:0]                       prog_addr,
    output logic                                          erase_req,
    output logic [ADDR_BYTES*8-1:0]                       erase_addr
);
    localparam int LEN_W = $clog2(PAGE_BYTES + (PAGE_BYTES >> 5) + 1);
    localparam int CNT_W = $clog2(ADDR_BYTES + 2);

    logic                   cmd_take, soft_clr, id_start, len_load, cyc_hit;
    logic [ADDR_BYTES*8-1:0] addr_nx;
    logic [CNT_W-1:0]       cyc_idx;
    logic [LEN_W-1:0]       len_val;
    op_e                    op_q;

    // The model never goes busy.
    assign rb_n = 1'b1;

    nandsp_addr_asm #(
        .ADDR_BYTES (ADDR_BYTES),
        .BUS16      (BUS16)
    ) addr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .cmd_take  (cmd_take),
        .byte_take (we_stb && ale),
        .din       (io_in),
        .addr_nx   (addr_nx),
        .cyc_hit   (cyc_hit),
        .cyc_idx   (cyc_idx)
    );

    nandsp_cmd_dec #(
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_BYTES (ADDR_BYTES)
    ) dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_stb     (we_stb),
        .ce_n       (ce_n),
        .cle        (cle),
        .ale        (ale),
        .wp_n       (wp_n),
        .gnd        (gnd),
        .din        (io_in),
        .addr_nx    (addr_nx),
        .cyc_hit    (cyc_hit),
        .cyc_idx    (cyc_idx),
        .cmd_take   (cmd_take),
        .soft_clr   (soft_clr),
        .op_q       (op_q),
        .id_start   (id_start),
        .len_load   (len_load),
        .len_val    (len_val),
        .load_req   (load_req),
        .load_addr  (load_addr),
        .load_col   (load_col),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .erase_req  (erase_req),
        .erase_addr (erase_addr),
        .wr_push    (wr_push),
        .wr_data    (wr_data)
    );

    nandsp_rd_path #(
        .MANF_ID (MANF_ID),
        .DEV_ID  (DEV_ID),
        .FILL_ID (FILL_ID),
        .LEN_W   (LEN_W)
    ) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .re_stb    (re_stb),
        .ce_n      (ce_n),
        .wp_n      (wp_n),
        .op        (op_q),
        .cmd_take  (cmd_take),
        .soft_clr  (soft_clr),
        .id_start  (id_start),
        .len_load  (len_load),
        .len_val   (len_val),
        .arr_rdata (arr_rdata),
        .io_out    (io_out),
        .arr_pop   (arr_pop)
    );

endmodule

// File: rtl/nandsp_front_chk.sv
// Checker for the NAND front end; attached by bind below.
// Assumes synchronous active-low reset is held low from time zero.
module nandsp_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       we_stb,
    input logic       re_stb,
    input logic       ce_n,
    input logic       ale,
    input logic       wp_n,
    input logic [7:0] io_out,
    input logic       load_req,
    input logic       prog_req,
    input logic       erase_req,
    input logic [7:0] erase_lo
);
    AST_CE_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (re_stb && ce_n) |=> (io_out == 8'h00));                          // R12
    AST_PROG_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wp_n));                                        // R9
    AST_ERASE_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(wp_n));                                       // R9
    AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (erase_lo == 8'h00 && $past(we_stb)));              // R8
    AST_LOAD_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> $past(we_stb && ale));                               // R3
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_req, prog_req, erase_req}));                       // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !re_stb |=> $stable(io_out));                                     // R10
endmodule

bind nandsp_front nandsp_front_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_stb    (we_stb),
    .re_stb    (re_stb),
    .ce_n      (ce_n),
    .ale       (ale),
    .wp_n      (wp_n),
    .io_out    (io_out),
    .load_req  (load_req),
    .prog_req  (prog_req),
    .erase_req (erase_req),
    .erase_lo  (erase_addr[7:0])
);

// File: tb/nandsp_front_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for the NAND front end: read tasks queue expected bytes,
// a monitor compares them with io_out after each read strobe.
module nandsp_front_tb_top;
    localparam int PAGE  = 512;
    localparam int FULL  = PAGE + PAGE / 32;
    localparam int COL_W = $clog2(FULL + 1) + 1;

    logic clk = 0, rst_n = 0;
    logic we_stb = 0, re_stb = 0, ce_n = 1, cle = 0, ale = 0, wp_n = 1, gnd = 0;
    logic [7:0] io_in = 0, io_out, arr_rdata, wr_data;
    logic rb_n, load_req, arr_pop, wr_push, prog_req, erase_req;
    logic [31:0] load_addr, prog_addr, erase_addr;
    logic [COL_W-1:0] load_col;

    int checks = 0, fails = 0;
    int n_load = 0, n_pop = 0, n_wr = 0, n_prog = 0, n_erase = 0;
    logic [31:0] l_addr = 0, p_addr = 0, e_addr = 0;
    logic [COL_W-1:0] l_col = 0, ptr = 0;
    logic [7:0] l_wd = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    bit done = 0;

    always #5 clk = ~clk;

    nandsp_front #(.MANF_ID(8'hEC), .DEV_ID(8'h75), .FILL_ID(8'hA5),
                   .PAGE_BYTES(PAGE), .ADDR_BYTES(4), .BUS16(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .we_stb(we_stb), .re_stb(re_stb), .ce_n(ce_n),
        .cle(cle), .ale(ale), .wp_n(wp_n), .gnd(gnd), .io_in(io_in), .io_out(io_out),
        .rb_n(rb_n), .load_req(load_req), .load_addr(load_addr), .load_col(load_col),
        .arr_rdata(arr_rdata), .arr_pop(arr_pop), .wr_push(wr_push), .wr_data(wr_data),
        .prog_req(prog_req), .prog_addr(prog_addr), .erase_req(erase_req),
        .erase_addr(erase_addr));

    // Array engine model: byte at column c is c[7:0]^0x5A.
    assign arr_rdata = ptr[7:0] ^ 8'h5A;

    // Request and handshake capture.
    always @(posedge clk) begin
        if (load_req) begin
            n_load <= n_load + 1; l_addr <= load_addr; l_col <= load_col; ptr <= load_col;
        end else if (arr_pop) ptr <= ptr + 1'b1;
        if (arr_pop) n_pop <= n_pop + 1;
        if (wr_push) begin n_wr <= n_wr + 1; l_wd <= wr_data; end
        if (prog_req) begin n_prog <= n_prog + 1; p_addr <= prog_addr; end
        if (erase_req) begin n_erase <= n_erase + 1; e_addr <= erase_addr; end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare io_out with the queued expectation after each read edge.
    always begin
        @(posedge clk);
        if (re_stb === 1'b1) begin
            #2;
            if (exp_q.size() == 0) chk(0, "scoreboard empty", {24'd0, io_out}, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(io_out === e, t, {24'd0, io_out}, {24'd0, e});
            end
        end
    end

    task automatic wr(input logic c, input logic a, input logic [7:0] d);
        @(negedge clk); cle = c; ale = a; io_in = d; we_stb = 1;
        @(negedge clk); we_stb = 0; cle = 0; ale = 0;
    endtask
    task automatic cmd(input logic [7:0] d); wr(1, 0, d); endtask
    task automatic adr(input logic [7:0] d); wr(0, 1, d); endtask
    task automatic dat(input logic [7:0] d); wr(0, 0, d); endtask
    task automatic rd(input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); re_stb = 1;
        @(negedge clk); re_stb = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int p0, l0, w0;
        idle(3); rst_n = 1; idle(2);
        // R13 and reset state
        chk(io_out == 8'h00, "reset io_out", {24'd0, io_out}, 0);
        chk(rb_n == 1'b1, "R13 ready", {31'd0, rb_n}, 1);
        chk(n_load == 0 && n_prog == 0 && n_erase == 0, "reset no requests", n_load, 0);
        ce_n = 0;

        // R5 identification stream
        cmd(8'h90); adr(8'h00);
        rd(8'hEC, "R5 manf"); rd(8'h75, "R5 dev"); rd(8'hA5, "R5 fill");
        rd(8'hC0, "R5 tail"); rd(8'h00, "R5 past end");

        // R10 status, R1 command with CE high ignored
        cmd(8'h70);
        rd(8'h80, "R10 status wp high");
        @(negedge clk); ce_n = 1;
        cmd(8'h90);
        @(negedge clk); ce_n = 0;
        rd(8'h80, "R1 ce high command ignored");
        @(negedge clk); wp_n = 0; idle(2);
        p0 = n_pop;
        rd(8'h00, "R10 status wp low"); rd(8'h00, "R10 status sticky");
        @(negedge clk); wp_n = 1; idle(2);
        rd(8'h80, "R10 status follows wp");
        chk(n_pop == p0, "R10 no pop on status", n_pop, p0);
        // R12 unknown code, CE high read
        cmd(8'h33);
        rd(8'h80, "R12 unknown code ignored");
        @(negedge clk); ce_n = 1;
        rd(8'h00, "R12 ce high read");
        @(negedge clk); ce_n = 0;

        // R2 / R3 address assembly and load on third cycle
        l0 = n_load;
        cmd(8'h00); adr(8'h10); adr(8'h34); idle(2);
        chk(n_load == l0, "R3 no load after two cycles", n_load, l0);
        adr(8'h12); idle(2);
        chk(n_load == l0 + 1, "R3 load on third cycle", n_load, l0 + 1);
        chk(l_addr == 32'h0012_3410, "R2 address lanes", l_addr, 32'h0012_3410);
        chk(l_col == COL_W'(16), "R4 read no offset", {21'd0, l_col}, 16);

        // R4 offset 256 and R6 read length to spare end
        p0 = n_pop;
        cmd(8'h01); adr(8'hF0); adr(8'h00); adr(8'h00); idle(2);
        chk(l_col == COL_W'(496), "R4 offset 256", {21'd0, l_col}, 496);
        for (int i = 0; i < FULL - 496; i++) rd(8'((496 + i) & 8'hFF) ^ 8'h5A, "R6 spare-end data");
        rd(8'h00, "R6 past spare end");
        idle(2);
        chk(n_pop == p0 + FULL - 496, "R6 pop count", n_pop, p0 + FULL - 496);

        // R4 spare offset, R6 length with gnd low
        cmd(8'h50); adr(8'h04); adr(8'h00); adr(8'h00); idle(2);
        chk(l_col == COL_W'(PAGE + 4), "R4 spare offset", {21'd0, l_col}, PAGE + 4);
        for (int i = 0; i < FULL - PAGE - 4; i++) rd(8'((PAGE + 4 + i) & 8'hFF) ^ 8'h5A, "R6 spare data");
        rd(8'h00, "R6 spare exhausted");

        // R6 gnd high stops at page end
        @(negedge clk); gnd = 1;
        cmd(8'h01); adr(8'hFF); adr(8'h00); adr(8'h00);
        rd(8'hFF ^ 8'h5A, "R6 last page byte");
        rd(8'h00, "R6 gnd stops at page end");
        @(negedge clk); gnd = 0;

        // R7 program with cap
        w0 = n_wr;
        cmd(8'h80); adr(8'h00); adr(8'h05); adr(8'h00);
        for (int i = 0; i < FULL + 2; i++) dat(8'(i));
        idle(2);
        chk(n_wr == w0 + FULL, "R7 program cap", n_wr, w0 + FULL);
        chk(l_wd == 8'((FULL - 1) & 8'hFF), "R7 last pushed byte", {24'd0, l_wd}, (FULL - 1) & 8'hFF);
        cmd(8'h10); idle(2);
        chk(n_prog == 1, "R7 program confirm", n_prog, 1);
        chk(p_addr == 32'h0000_0500, "R7 program address", p_addr, 32'h0000_0500);

        // R9 program blocked
        @(negedge clk); wp_n = 0;
        cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00); dat(8'h3C); cmd(8'h10); idle(2);
        chk(n_prog == 1, "R9 program blocked", n_prog, 1);

        // R8 erase, R9 erase blocked
        cmd(8'h60); adr(8'h40); adr(8'h01); cmd(8'hD0); idle(2);
        chk(n_erase == 0, "R9 erase blocked", n_erase, 0);
        @(negedge clk); wp_n = 1;
        cmd(8'h60); adr(8'h40); adr(8'h01); cmd(8'hD0); idle(2);
        chk(n_erase == 1, "R8 erase confirm", n_erase, 1);
        chk(e_addr == 32'h0001_4000, "R8 erase address", e_addr, 32'h0001_4000);

        // R11 reset clears offset and mode
        l0 = n_load;
        cmd(8'h50); cmd(8'hFF); adr(8'h20); adr(8'h00); adr(8'h00); idle(2);
        chk(n_load == l0 + 1, "R11 read mode after reset", n_load, l0 + 1);
        chk(l_col == COL_W'(32), "R11 offset cleared", {21'd0, l_col}, 32);
        chk(l_addr == 32'h0000_0020, "R11 address cleared", l_addr, 32'h0000_0020);
        cmd(8'h70);
        rd(8'h80, "R11 status after reset");
        chk(rb_n == 1'b1, "R13 ready at end", {31'd0, rb_n}, 1);

        idle(4);
        finish_run();
    end
endmodule